// File: doc/BRIEF.md
# Two-Initiator Crossbar with Per-Target Arbitration

This block connects two bus initiators, a processor port and a DMA port, to four target ports: a flash memory, an SRAM, a peripheral bus that both initiators share, and a peripheral bus reserved for the processor. Each initiator drives one request at a time: a valid flag, an address, write data and a write enable. It holds these until the crossbar returns ready. In the ready cycle the read data and an error flag are valid.

Every target has its own two-way round-robin arbiter. Two initiators that address different targets are served in the same cycle. The DMA port is checked against a permission map. A DMA request for the processor-only bus, or any request to an address outside the four windows, is answered locally in the same cycle with the error flag set, and no target sees it.

Top module: `dual_init_xbar`

## Requirements
- R1: After reset no target valid and no initiator ready is asserted, and every arbiter favours the processor port the first time both ports contend for it.
- R2: Addresses route by window: 0x0000_0000–0x0FFF_FFFF to target 0 (flash), 0x2000_0000–0x2FFF_FFFF to target 1 (SRAM), 0x4000_0000–0x47FF_FFFF to target 2 (shared peripherals), 0x4800_0000–0x4FFF_FFFF to target 3 (processor-only peripherals). Address, write data and write enable pass through unchanged to the selected target.
- R3: A request to an address outside all four windows gets ready and error in the same cycle, and no target valid is raised for it.
- R4: A DMA request to the processor-only window gets ready and error in the same cycle and never raises target 3's valid. Target 3 is driven only by the processor port.
- R5: A lone requester at an idle target is granted in the same cycle it raises valid, and it completes in that cycle if the target is ready.
- R6: When both ports request one target, the arbiter of that target alternates between them. After each completed transfer at a target, that target's arbiter favours the other port. Each target keeps its own pointer.
- R7: Once granted, a port keeps the target until the target returns ready, even if the other port is then favoured. Target-side address and write enable stay stable while ready is low.
- R8: The processor port and the DMA port complete in the same cycle when they address different targets.
- R9: Read data and error from a target return only to the port that was granted. The other port sees no ready for that transfer.
- R10: The processor completes an access to the processor-only bus in the same cycle that the DMA completes on the shared peripheral bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_addr | input | 32 | Processor address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_ready | output | 1 | Processor transfer complete |
| cpu_rdata | output | 32 | Processor read data |
| cpu_err | output | 1 | Processor error response |
| dma_valid | input | 1 | DMA request valid |
| dma_addr | input | 32 | DMA address |
| dma_wdata | input | 32 | DMA write data |
| dma_we | input | 1 | DMA write enable |
| dma_ready | output | 1 | DMA transfer complete |
| dma_rdata | output | 32 | DMA read data |
| dma_err | output | 1 | DMA error response |
| tgt_valid | output | 4 | Per-target request valid |
| tgt_addr | output | 4x32 | Per-target address |
| tgt_wdata | output | 4x32 | Per-target write data |
| tgt_we | output | 4 | Per-target write enable |
| tgt_ready | input | 4 | Per-target completion |
| tgt_rdata | input | 4x32 | Per-target read data |
| tgt_err | input | 4 | Per-target error |

## Verification
The bench contends both ports for a target right after reset. A design with the wrong reset pointer would serve the DMA first. It then alternates grants over several cycles, which catches a pointer that never moves or that moves on request instead of completion. It also checks that the shared bus and the SRAM keep separate pointers, so a single global pointer would show up there. A stalled target with a DMA request arriving while the pointer already favours the DMA exposes a grant that is not held. The bench also sends a DMA request to the processor-only window and a request to an unmapped address, so a missing permission check or decode error would show as a leaked target valid or a missing error. Concurrent accesses to different targets, plus a target error injected on one side, expose serialised arbitration and crossed response routing.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int N_TGT  = 4;
    localparam int N_INI  = 2;

    // Which targets the DMA port may reach (bit per target index)
    localparam logic [N_TGT-1:0] DMA_ALLOWED = 4'b0111;

    typedef enum logic [2:0] {
        TGT_FLASH = 3'd0,
        TGT_SRAM  = 3'd1,
        TGT_PSHR  = 3'd2,
        TGT_PCPU  = 3'd3,
        TGT_NONE  = 3'd4
    } tgt_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
    } req_t;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    function automatic tgt_e decode_addr(input logic [ADDR_W-1:0] a);
        tgt_e r;
        if (a[ADDR_W-1 -: 4] == 4'h0)
            r = TGT_FLASH;
        else if (a[ADDR_W-1 -: 4] == 4'h2)
            r = TGT_SRAM;
        else if (a[ADDR_W-1 -: 5] == 5'b01000)
            r = TGT_PSHR;
        else if (a[ADDR_W-1 -: 5] == 5'b01001)
            r = TGT_PCPU;
        else
            r = TGT_NONE;
        return r;
    endfunction

endpackage

// File: rtl/xbar_decoder.sv
`timescale 1ns/1ps
module xbar_decoder
    import xbar_pkg::*;
#(
    parameter bit IS_DMA = 1'b0
) (
    input  req_t             req,
    output logic [N_TGT-1:0] sel,
    output logic             dec_err
);

    tgt_e tgt;

    always_comb begin
        tgt     = decode_addr(req.addr);
        sel     = '0;
        dec_err = 1'b0;
        if (req.valid) begin
            if (tgt == TGT_NONE) begin
                dec_err = 1'b1;
            end else if (IS_DMA && !DMA_ALLOWED[tgt[1:0]]) begin
                dec_err = 1'b1;
            end else begin
                sel[tgt[1:0]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xbar_tgt_arb.sv
`timescale 1ns/1ps
module xbar_tgt_arb
    import xbar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_INI-1:0] req,
    input  logic             tgt_ready,
    output logic [N_INI-1:0] gnt
);

    logic lock_q;
    logic owner_q;   // 0: processor, 1: DMA
    logic ptr_q;     // favoured port on contention

    always_comb begin
        if (lock_q)
            gnt = owner_q ? 2'b10 : 2'b01;
        else if (req == 2'b11)
            gnt = ptr_q ? 2'b10 : 2'b01;
        else
            gnt = req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            owner_q <= 1'b0;
            ptr_q   <= 1'b0;
        end else if (|gnt) begin
            if (tgt_ready) begin
                lock_q <= 1'b0;
                ptr_q  <= ~gnt[1];
            end else begin
                lock_q  <= 1'b1;
                owner_q <= gnt[1];
            end
        end
    end

endmodule

// File: rtl/xbar_rsp_mux.sv
`timescale 1ns/1ps
module xbar_rsp_mux
    import xbar_pkg::*;
(
    input  logic [N_TGT-1:0]             gnt_col,
    input  logic [N_TGT-1:0]             tgt_ready,
    input  logic [N_TGT-1:0][DATA_W-1:0] tgt_rdata,
    input  logic [N_TGT-1:0]             tgt_err,
    input  logic                         dec_err,
    output rsp_t                         rsp
);

    always_comb begin
        rsp = '0;
        if (dec_err) begin
            rsp.ready = 1'b1;
            rsp.err   = 1'b1;
        end
        for (int t = 0; t < N_TGT; t++) begin
            if (gnt_col[t]) begin
                rsp.ready = tgt_ready[t];
                rsp.rdata = tgt_rdata[t];
                rsp.err   = tgt_err[t];
            end
        end
    end

endmodule

// File: rtl/dual_init_xbar.sv
`timescale 1ns/1ps
module dual_init_xbar
    import xbar_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cpu_valid,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    input  logic                         cpu_we,
    output logic                         cpu_ready,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_err,
    input  logic                         dma_valid,
    input  logic [ADDR_W-1:0]            dma_addr,
    input  logic [DATA_W-1:0]            dma_wdata,
    input  logic                         dma_we,
    output logic                         dma_ready,
    output logic [DATA_W-1:0]            dma_rdata,
    output logic                         dma_err,
    output logic [N_TGT-1:0]             tgt_valid,
    output logic [N_TGT-1:0][ADDR_W-1:0] tgt_addr,
    output logic [N_TGT-1:0][DATA_W-1:0] tgt_wdata,
    output logic [N_TGT-1:0]             tgt_we,
    input  logic [N_TGT-1:0]             tgt_ready,
    input  logic [N_TGT-1:0][DATA_W-1:0] tgt_rdata,
    input  logic [N_TGT-1:0]             tgt_err
);

    req_t             cpu_req, dma_req;
    rsp_t             cpu_rsp, dma_rsp;
    logic [N_TGT-1:0] cpu_sel, dma_sel;
    logic             cpu_dec_err, dma_dec_err;
    logic [N_TGT-1:0] gnt_cpu, gnt_dma;

    assign cpu_req = '{valid: cpu_valid, addr: cpu_addr, wdata: cpu_wdata, we: cpu_we};
    assign dma_req = '{valid: dma_valid, addr: dma_addr, wdata: dma_wdata, we: dma_we};

    xbar_decoder #(.IS_DMA(1'b0)) u_dec_cpu (
        .req(cpu_req), .sel(cpu_sel), .dec_err(cpu_dec_err)
    );
    xbar_decoder #(.IS_DMA(1'b1)) u_dec_dma (
        .req(dma_req), .sel(dma_sel), .dec_err(dma_dec_err)
    );

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        logic [N_INI-1:0] req_v;
        logic [N_INI-1:0] gnt_v;

        assign req_v = {dma_sel[t] & DMA_ALLOWED[t], cpu_sel[t]};

        xbar_tgt_arb u_arb (
            .clk(clk), .rst(rst), .req(req_v),
            .tgt_ready(tgt_ready[t]), .gnt(gnt_v)
        );

        assign gnt_cpu[t]   = gnt_v[0];
        assign gnt_dma[t]   = gnt_v[1];
        assign tgt_valid[t] = |gnt_v;
        assign tgt_addr[t]  = gnt_v[1] ? dma_req.addr  : cpu_req.addr;
        assign tgt_wdata[t] = gnt_v[1] ? dma_req.wdata : cpu_req.wdata;
        assign tgt_we[t]    = gnt_v[1] ? dma_req.we    : cpu_req.we;
    end

    xbar_rsp_mux u_rsp_cpu (
        .gnt_col(gnt_cpu), .tgt_ready(tgt_ready), .tgt_rdata(tgt_rdata),
        .tgt_err(tgt_err), .dec_err(cpu_dec_err), .rsp(cpu_rsp)
    );
    xbar_rsp_mux u_rsp_dma (
        .gnt_col(gnt_dma), .tgt_ready(tgt_ready), .tgt_rdata(tgt_rdata),
        .tgt_err(tgt_err), .dec_err(dma_dec_err), .rsp(dma_rsp)
    );

    assign cpu_ready = cpu_rsp.ready;
    assign cpu_rdata = cpu_rsp.rdata;
    assign cpu_err   = cpu_rsp.err;
    assign dma_ready = dma_rsp.ready;
    assign dma_rdata = dma_rsp.rdata;
    assign dma_err   = dma_rsp.err;

endmodule

// File: rtl/xbar_chk.sv
`timescale 1ns/1ps
module xbar_chk
    import xbar_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         cpu_valid,
    input logic [ADDR_W-1:0]            cpu_addr,
    input logic                         cpu_ready,
    input logic                         cpu_err,
    input logic                         dma_valid,
    input logic [ADDR_W-1:0]            dma_addr,
    input logic                         dma_ready,
    input logic                         dma_err,
    input logic [N_TGT-1:0]             tgt_valid,
    input logic [N_TGT-1:0][ADDR_W-1:0] tgt_addr,
    input logic [N_TGT-1:0]             tgt_we,
    input logic [N_TGT-1:0]             tgt_ready
);

    // R3: unmapped processor request answered at once with error
    p_unmapped_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_valid && decode_addr(cpu_addr) == TGT_NONE |-> cpu_ready && cpu_err);

    // R4: DMA to the processor-only window errors immediately
    p_dma_barred_r4: assert property (@(posedge clk) disable iff (rst)
        dma_valid && decode_addr(dma_addr) == TGT_PCPU |-> dma_ready && dma_err);

    // R4: the processor-only target is driven only by the processor
    p_pcpu_owner_r4: assert property (@(posedge clk) disable iff (rst)
        tgt_valid[3] |-> cpu_valid && decode_addr(cpu_addr) == TGT_PCPU);

    // R9: no response without a request
    p_cpu_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_valid);
    p_dma_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        dma_ready |-> dma_valid);

    // R7: a stalled target keeps its request stable
    for (genvar t = 0; t < N_TGT; t++) begin : g_hold
        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            tgt_valid[t] && !tgt_ready[t] |=>
                tgt_valid[t] && $stable(tgt_addr[t]) && $stable(tgt_we[t]));
    end

endmodule

bind dual_init_xbar xbar_chk u_chk (.*);

// File: tb/tb_dual_init_xbar.sv
`timescale 1ns/1ps
module tb_dual_init_xbar;
    import xbar_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                         cpu_valid, cpu_we, cpu_ready, cpu_err;
    logic [ADDR_W-1:0]            cpu_addr;
    logic [DATA_W-1:0]            cpu_wdata, cpu_rdata;
    logic                         dma_valid, dma_we, dma_ready, dma_err;
    logic [ADDR_W-1:0]            dma_addr;
    logic [DATA_W-1:0]            dma_wdata, dma_rdata;
    logic [N_TGT-1:0]             tgt_valid, tgt_we, tgt_ready, tgt_err;
    logic [N_TGT-1:0][ADDR_W-1:0] tgt_addr;
    logic [N_TGT-1:0][DATA_W-1:0] tgt_wdata, tgt_rdata;
    logic [N_TGT-1:0]             stall, err_inj;

    int checks = 0;
    int errors = 0;

    dual_init_xbar dut (.*);

    // Simple targets: read data is the address mixed with a per-target salt
    function automatic logic [DATA_W-1:0] salt(input int t);
        return 32'h5A5A_0000 | DATA_W'(t);
    endfunction

    assign tgt_ready = ~stall;
    assign tgt_err   = err_inj;
    for (genvar t = 0; t < N_TGT; t++) begin : g_mdl
        assign tgt_rdata[t] = tgt_addr[t] ^ salt(t);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cpu_valid = 0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 0;
        dma_valid = 0; dma_addr = '0; dma_wdata = '0; dma_we = 0;
    endtask

    task automatic apply_reset();
        idle();
        stall = '0; err_inj = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        apply_reset();
        #1;
        chk("R1 tgt_valid", 64'(tgt_valid), 64'h0);
        chk("R1 cpu_ready", 64'(cpu_ready), 64'h0);
        chk("R1 dma_ready", 64'(dma_ready), 64'h0);
    endtask

    task automatic t_contend();
        apply_reset();
        cpu_valid = 1; cpu_addr = 32'h2000_0100;
        dma_valid = 1; dma_addr = 32'h2000_0200;
        #1;
        chk("R1 first grant cpu", 64'(tgt_addr[1]), 64'h2000_0100);
        chk("R6 cpu ready", 64'({cpu_ready, dma_ready}), 64'b10);
        @(negedge clk);
        cpu_addr = 32'h2000_0104;
        #1;
        chk("R6 dma next", 64'(tgt_addr[1]), 64'h2000_0200);
        chk("R6 dma ready", 64'({cpu_ready, dma_ready}), 64'b01);
        chk("R9 dma rdata", 64'(dma_rdata), 64'(32'h2000_0200 ^ salt(1)));
        @(negedge clk);
        dma_addr = 32'h2000_0204;
        #1;
        chk("R6 cpu again", 64'(tgt_addr[1]), 64'h2000_0104);
        @(negedge clk);
        // SRAM now favours DMA; shared bus pointer untouched still favours CPU
        cpu_addr = 32'h4000_0010; dma_addr = 32'h4000_0020;
        #1;
        chk("R6 separate pointer", 64'(tgt_addr[2]), 64'h4000_0010);
        @(negedge clk);
        idle();
        @(negedge clk);
        cpu_valid = 1; cpu_addr = 32'h2000_0300;
        dma_valid = 1; dma_addr = 32'h2000_0400;
        #1;
        chk("R6 sram favours dma", 64'({cpu_ready, dma_ready}), 64'b01);
        @(negedge clk);
        idle();
    endtask

    task automatic t_decode();
        logic [ADDR_W-1:0] a [4];
        apply_reset();
        a[0] = 32'h0000_1230; a[1] = 32'h2000_0450;
        a[2] = 32'h4000_0670; a[3] = 32'h4800_0890;
        for (int i = 0; i < 4; i++) begin
            cpu_valid = 1; cpu_addr = a[i]; cpu_we = 1; cpu_wdata = 32'hC0DE_0000 + i;
            #1;
            chk("R2 cpu route", 64'(tgt_valid), 64'(1 << i));
            chk("R2 cpu fields", {tgt_addr[i], tgt_wdata[i]}, {a[i], 32'hC0DE_0000 + i});
            chk("R2 cpu we", 64'(tgt_we[i]), 64'h1);
            chk("R5 cpu same cycle", 64'({cpu_ready, cpu_err}), 64'b10);
            chk("R5 cpu rdata", 64'(cpu_rdata), 64'(a[i] ^ salt(i)));
            @(negedge clk);
            idle();
        end
        for (int i = 0; i < 3; i++) begin
            dma_valid = 1; dma_addr = a[i] + 32'h8;
            #1;
            chk("R2 dma route", 64'(tgt_valid), 64'(1 << i));
            chk("R5 dma same cycle", 64'({dma_ready, dma_err}), 64'b10);
            @(negedge clk);
            idle();
        end
    endtask

    task automatic t_errors();
        apply_reset();
        cpu_valid = 1; cpu_addr = 32'h3000_0000;
        #1;
        chk("R3 unmapped resp", 64'({cpu_ready, cpu_err}), 64'b11);
        chk("R3 no target", 64'(tgt_valid), 64'h0);
        @(negedge clk);
        idle();
        dma_valid = 1; dma_addr = 32'h4800_0010;
        #1;
        chk("R4 dma barred resp", 64'({dma_ready, dma_err}), 64'b11);
        chk("R4 no target", 64'(tgt_valid), 64'h0);
        @(negedge clk);
        idle();
    endtask

    task automatic t_hold();
        apply_reset();
        cpu_valid = 1; cpu_addr = 32'h4000_0004;   // move shared pointer to DMA
        @(negedge clk);
        stall[2] = 1; cpu_addr = 32'h4000_0040; cpu_we = 1;
        #1;
        chk("R7 granted stalled", 64'({tgt_valid[2], cpu_ready}), 64'b10);
        @(negedge clk);
        dma_valid = 1; dma_addr = 32'h4000_0080;
        #1;
        chk("R7 grant held", 64'(tgt_addr[2]), 64'h4000_0040);
        chk("R7 dma waits", 64'(dma_ready), 64'h0);
        @(negedge clk);
        #1;
        chk("R7 still held", 64'(tgt_addr[2]), 64'h4000_0040);
        @(negedge clk);
        stall[2] = 0;
        #1;
        chk("R7 cpu completes", 64'({cpu_ready, dma_ready}), 64'b10);
        @(negedge clk);
        cpu_valid = 0;
        #1;
        chk("R7 dma after release", 64'({dma_ready, tgt_addr[2]}), {1'b1, 32'h4000_0080});
        @(negedge clk);
        idle();
    endtask

    task automatic t_parallel();
        apply_reset();
        cpu_valid = 1; cpu_addr = 32'h0000_0100;
        dma_valid = 1; dma_addr = 32'h2000_0100;
        #1;
        chk("R8 both ready", 64'({cpu_ready, dma_ready}), 64'b11);
        @(negedge clk);
        cpu_addr = 32'h4800_0200; dma_addr = 32'h4000_0300;
        #1;
        chk("R10 both ready", 64'({cpu_ready, dma_ready, cpu_err, dma_err}), 64'b1100);
        chk("R10 targets", 64'(tgt_valid), 64'b1100);
        @(negedge clk);
        err_inj[0] = 1;
        cpu_addr = 32'h0000_0500; dma_addr = 32'h2000_0600;
        #1;
        chk("R9 err routed", 64'({cpu_err, dma_err}), 64'b10);
        chk("R9 dma rdata", 64'(dma_rdata), 64'(32'h2000_0600 ^ salt(1)));
        @(negedge clk);
        idle(); err_inj = '0;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_contend();
        t_decode();
        t_errors();
        t_hold();
        t_parallel();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule